// File: doc/BRIEF.md
# Reset Line Controller with Settled-State Readback

This block drives a bank of reset lines from a small register map. Software asserts or releases each line by writing one bit per line into a set of 32-bit hold registers. It reads each line's settled state back from a matching set of status registers. Every line leaves power-on reset held in reset. A line's reset output follows its register bit in the cycle after the write. Its settled state then travels through a short per-line synchronizer. That synchronizer only advances in cycles where the line's clock-enable input is high.

The status bits do not all have the same polarity. A constant per-line pattern gives the value a line shows while it is held. A released line shows the inverse of that value. Software that releases a line and then polls its status therefore sees no completion while that line's clock is gated. The poll has to time out on its own.

The register bus is plain and is not a stream. A write strobe commits the write data in the same cycle. A read strobe returns the read data on the next cycle, and that value is held until the next read. There is no back-pressure, and every access completes in a single cycle.

Top module: `rstline_ctrl`

## Requirements
- R1: After reset every line output is 1 (held), and each hold register reads back as 0xFFFFFFFF.
- R2: A write to byte offset 4*m (m below 4) sets line 32*m+n to bit n of the write data, and the line output shows it from the next cycle on. Lines 64k to 64k+63 form one 64-bit pair, with the low word at the lower offset.
- R3: A read at offset 4*m returns the current hold register m on rdata in the cycle after the read strobe.
- R4: A read at offset 0x10+4*m returns status word m. Each bit equals the line's polarity bit while the line has settled held, and the inverse of that bit once it has settled released. The default polarity bit is 1 for lines 5, 6, 7, 9, 10 and 68 and 0 for all others.
- R5: With the clock enable high, a change of a line output reaches its status bit on the second edge after the write. A status read issued in either of the first two cycles after the write returns the old value. Cycles with the enable low do not count toward the two.
- R6: While a line's clock enable is low, its status bit does not change. A release on a gated line therefore never shows as complete until the enable returns.
- R7: Writes to the status offsets 0x10 to 0x1C change no line output and no hold register.
- R8: A read at any offset from 0x20 upward returns 0. A write there changes no line output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address; bits 1:0 are ignored |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, committed on the same edge |
| rd_en | input | 1 | Read strobe; rdata is valid in the next cycle |
| rdata | output | 32 | Read data, held until the next read |
| line_rst | output | 128 | Reset output per line, 1 = held in reset |
| line_clk_en | input | 128 | Per-line clock-running indication that gates status progress |

## Verification
The hardest case to reach is a status bit that is stuck partway through its synchronizer. The bench gets there by keeping one word's clock enables low while it writes a new hold value. It then raises the enable for exactly one cycle, reads, raises it for one more cycle, and reads again. Only the second read may show the new state. A release on a fully gated word is held for many cycles and read as still held before the enable comes back. After that the release is read as complete.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int WORD_W = 32;

  // Lines whose status reads 1 while held in reset (most read 0 when held)
  localparam logic [127:0] DEF_HELD_HIGH =
    128'h00000000_00000010_00000000_000006E0;

  typedef enum logic [1:0] {
    RGN_HOLD   = 2'd0,
    RGN_STATUS = 2'd1,
    RGN_NONE   = 2'd2
  } region_e;
endpackage

// File: rtl/rstctl_hold_regs.sv
module rstctl_hold_regs
  import rstctl_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int SEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [SEL_W-1:0]       sel,
  input  logic [WORD_W-1:0]      wdata,
  output logic [NREG*WORD_W-1:0] hold_q
);
  for (genvar w = 0; w < NREG; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hold_q[w*WORD_W +: WORD_W] <= '1;
      else if (we && sel == SEL_W'(w))
        hold_q[w*WORD_W +: WORD_W] <= wdata;
    end
  end
endmodule

// File: rtl/rstctl_line_sync.sv
module rstctl_line_sync #(
  parameter int LINES  = 128,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] run,
  output logic [LINES-1:0] settled
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chain <= '1;
      else if (run[i])
        chain <= {chain[STAGES-2:0], req[i]};
    end
    assign settled[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/rstctl_readback.sv
module rstctl_readback
  import rstctl_pkg::*;
#(
  parameter int                 LINES     = 128,
  parameter int                 NREG      = 4,
  parameter int                 SEL_W     = 2,
  parameter logic [LINES-1:0]   HELD_HIGH = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  region_e                rgn,
  input  logic [SEL_W-1:0]       sel,
  input  logic [NREG*WORD_W-1:0] hold_q,
  input  logic [LINES-1:0]       settled,
  output logic [LINES-1:0]       stat_vec,
  output logic [WORD_W-1:0]      rdata
);
  localparam int PADW = NREG * WORD_W;

  logic [PADW-1:0]   stat_pad;
  logic [WORD_W-1:0] mux;

  // held -> polarity bit, released -> its inverse
  assign stat_vec = ~(settled ^ HELD_HIGH);

  always_comb begin
    stat_pad = '0;
    stat_pad[LINES-1:0] = stat_vec;
  end

  always_comb begin
    unique case (rgn)
      RGN_HOLD:   mux = hold_q[sel*WORD_W +: WORD_W];
      RGN_STATUS: mux = stat_pad[sel*WORD_W +: WORD_W];
      default:    mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= mux;
  end
endmodule

// File: rtl/rstline_ctrl.sv
module rstline_ctrl
  import rstctl_pkg::*;
#(
  parameter int               NUM_LINES   = 128,
  parameter int               ADDR_W      = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [NUM_LINES-1:0] HELD_HIGH = DEF_HELD_HIGH[NUM_LINES-1:0]
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [WORD_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] line_rst,
  input  logic [NUM_LINES-1:0] line_clk_en
);
  localparam int NREG  = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int PADW  = NREG * WORD_W;
  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [IDX_W-1:0]     widx;
  region_e              rgn;
  logic [SEL_W-1:0]     sel;
  logic [PADW-1:0]      hold_q;
  logic [NUM_LINES-1:0] settled;
  logic [NUM_LINES-1:0] stat_vec;

  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    if (widx < IDX_W'(NREG)) begin
      rgn = RGN_HOLD;
      sel = SEL_W'(widx);
    end else if (widx < IDX_W'(2*NREG)) begin
      rgn = RGN_STATUS;
      sel = SEL_W'(widx - IDX_W'(NREG));
    end else begin
      rgn = RGN_NONE;
      sel = '0;
    end
  end

  rstctl_hold_regs #(.NREG(NREG), .SEL_W(SEL_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_en && rgn == RGN_HOLD),
    .sel    (sel),
    .wdata  (wdata),
    .hold_q (hold_q)
  );

  assign line_rst = hold_q[NUM_LINES-1:0];

  rstctl_line_sync #(.LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (line_rst),
    .run     (line_clk_en),
    .settled (settled)
  );

  rstctl_readback #(
    .LINES(NUM_LINES), .NREG(NREG), .SEL_W(SEL_W), .HELD_HIGH(HELD_HIGH)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rgn      (rgn),
    .sel      (sel),
    .hold_q   (hold_q),
    .settled  (settled),
    .stat_vec (stat_vec),
    .rdata    (rdata)
  );
endmodule

// File: rtl/rstline_ctrl_chk.sv
module rstline_ctrl_chk #(
  parameter int NUM_LINES = 128,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wdata,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [31:0]          rdata,
  input logic [NUM_LINES-1:0] line_rst,
  input logic [NUM_LINES-1:0] line_clk_en,
  input logic [NUM_LINES-1:0] stat_vec
);
  localparam int NREG  = (NUM_LINES + 31) / 32;
  localparam int FULL  = NUM_LINES / 32;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  assign widx = addr[ADDR_W-1:2];

  p_held_at_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> &line_rst);

  for (genvar w = 0; w < FULL; w++) begin : g_wr
    p_write_drives_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && widx == IDX_W'(w)) |=> line_rst[w*32 +: 32] == $past(wdata));
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_gate
    p_gated_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !line_clk_en[i] |=> $stable(stat_vec[i]));
  end

  p_status_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx >= IDX_W'(NREG)) |=> $stable(line_rst));

  p_unmapped_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && widx >= IDX_W'(2*NREG)) |=> rdata == '0);
endmodule

bind rstline_ctrl rstline_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rstline_ctrl_test.sv
module rstline_ctrl_test;
  localparam logic [127:0] PAT = 128'h00000000_00000010_00000000_000006E0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [31:0]  rdata;
  logic [127:0] line_rst;
  logic [127:0] line_clk_en = '1;

  int vectors = 0;
  int fails   = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  rstline_ctrl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .line_rst(line_rst), .line_clk_en(line_clk_en)
  );

  function automatic logic [31:0] stat_of(input logic [31:0] held, input int w);
    return ~(held ^ PAT[w*32 +: 32]);
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  initial begin
    forever begin
      @(negedge clk);
      if (rd_seen) begin
        if (exp_q.size() == 0) begin
          check("monitor: unexpected read", 128'(rdata), 128'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, 128'(rdata), 128'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [127:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 lines held after reset", line_rst, '1);
    check("R1 rdata zero after reset", 128'(rdata), 128'h0);
    for (int m = 0; m < 4; m++) rd(8'(4*m), 32'hFFFF_FFFF, "R1 hold reg reset value");
    for (int m = 0; m < 4; m++) rd(8'(8'h10 + 4*m), PAT[m*32 +: 32], "R4 status when held");

    // R2 / R5: release most of word 0 and watch the status lag
    wr(8'h00, 32'h0000_00FF);
    check("R2 word0 lines follow write", 128'(line_rst[31:0]), 128'h0000_00FF);
    rd(8'h10, stat_of(32'hFFFF_FFFF, 0), "R5 status old one cycle after write");
    rd(8'h10, stat_of(32'hFFFF_FFFF, 0), "R5 status old two cycles after write");
    rd(8'h10, stat_of(32'h0000_00FF, 0), "R4 R5 status settled mixed polarity");
    rd(8'h00, 32'h0000_00FF, "R3 hold readback word0");

    // R6: release a gated word
    line_clk_en[95:64] = '0;
    wr(8'h08, 32'h0000_0000);
    check("R2 word2 released on gated clock", 128'(line_rst[95:64]), 128'h0);
    repeat (10) @(negedge clk);
    rd(8'h18, stat_of(32'hFFFF_FFFF, 2), "R6 gated release not complete");
    line_clk_en[95:64] = '1;
    repeat (3) @(negedge clk);
    rd(8'h18, stat_of(32'h0000_0000, 2), "R6 release completes after enable");

    // R5: enabled cycles counted one at a time on word3
    line_clk_en[127:96] = '0;
    wr(8'h0C, 32'hA5A5_5A5A);
    line_clk_en[127:96] = '1;
    @(negedge clk);
    line_clk_en[127:96] = '0;
    rd(8'h1C, stat_of(32'hFFFF_FFFF, 3), "R5 one enabled cycle is not enough");
    line_clk_en[127:96] = '1;
    @(negedge clk);
    line_clk_en[127:96] = '0;
    rd(8'h1C, stat_of(32'hA5A5_5A5A, 3), "R5 settled after second enabled cycle");
    line_clk_en[127:96] = '1;
    rd(8'h0C, 32'hA5A5_5A5A, "R3 hold readback word3");
    check("R2 64-bit pair low word at lower offset", 128'(line_rst[127:64]),
          128'({32'hA5A5_5A5A, 32'h0000_0000}));

    // R7: writes to status offsets ignored
    snap = line_rst;
    wr(8'h14, 32'h0000_0000);
    check("R7 status write leaves lines", line_rst, snap);
    rd(8'h04, 32'hFFFF_FFFF, "R7 hold word1 unchanged");
    rd(8'h14, stat_of(32'hFFFF_FFFF, 1), "R7 status word1 unchanged");

    // R8: unmapped space
    rd(8'h20, 32'h0, "R8 unmapped read 0x20");
    rd(8'hFC, 32'h0, "R8 unmapped read 0xFC");
    wr(8'h30, 32'h0000_0000);
    check("R8 unmapped write leaves lines", line_rst, snap);

    repeat (3) @(negedge clk);
    check("monitor queue drained", 128'(exp_q.size()), 128'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule